// File: doc/BRIEF.md
# Local interrupt request prioritizer

This block sits beside one processor core and decides which of 256 interrupt vectors the core should take next. Interrupt messages arrive one per cycle, each carrying a vector, a destination, a destination-mode flag, a delivery mode and a trigger type. A message addressed to this core with a maskable delivery mode is latched into a 256-bit request array. The block also records, for each newly latched vector, whether it was level- or edge-triggered.

The block keeps two 8-bit vectors: the highest pending vector and the vector last taken into service. A request line to the core rises when the pending vector is above the in-service vector, the core has interrupts enabled, and the pending vector's priority class is above the task priority class. The priority class is the upper four bits of a vector. When the core acknowledges, the block moves the vector into service, drives the delivered vector for that cycle, and finds the next highest pending vector from the bits that remain.

Messages with an unmaskable delivery mode are not queued. They set a sticky error flag instead. Software sets the task priority through a plain write port.

Top module: `irq_prioritizer`

## Requirements
- R1: A message is accepted when `msg_logical` is 0 and `msg_dest` equals `local_id`. It is also accepted when `msg_logical` is 1, `local_id` is below 8, and bit `local_id` of `msg_dest` is 1.
- R2: An accepted message whose `msg_mode` is 0 or 1 (maskable) sets bit `msg_vector` of `irr`, one cycle later, when that bit is clear.
- R3: When a request bit goes from 0 to 1, bit `msg_vector` of `tmr` takes `msg_level` (1 = level, 0 = edge). A message for a vector that is already pending leaves `tmr` unchanged.
- R4: On an accepted maskable message, `pend_vec` rises to `msg_vector` when that vector is larger. Outside an acknowledge, `pend_vec` never falls.
- R5: `irq_req` is high only when three conditions hold: `pend_vec` > `svc_vec`, `intr_en` = 1, and `pend_vec[7:4]` > `tpr[7:4]`.
- R6: An acknowledge is `irq_ack` while `irq_req` is high. In that cycle `ack_valid` is 1 and `ack_vector` equals `pend_vec`. On the next cycle `svc_vec` holds that vector, its `isr` bit is set and its `irr` bit is clear. `irq_ack` while `irq_req` is low changes nothing.
- R7: After an acknowledge, `pend_vec` becomes the index of the highest set bit left in `irr`, or 0 when `irr` is empty.
- R8: An accepted message with `msg_mode` from 2 to 7 (unmaskable) leaves `irr` and `pend_vec` unchanged. It sets `err_unmaskable`, which only reset clears. A message that is not accepted never sets the flag.
- R9: With `tpr_we` high, `tpr` takes `tpr_wdata` on the next cycle.
- R10: Synchronous reset clears `irr`, `isr`, `tmr`, `pend_vec`, `svc_vec`, `tpr` and `err_unmaskable`, and holds `irq_req` and `ack_valid` low.
- R11: A message that fails the R1 address test has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| local_id | input | 8 | Identifier of this core |
| msg_valid | input | 1 | Message present this cycle |
| msg_vector | input | 8 | Interrupt vector of the message |
| msg_dest | input | 8 | Destination ID or logical bitmask |
| msg_logical | input | 1 | 0 = physical destination, 1 = logical bitmask |
| msg_mode | input | 3 | Delivery mode; 0 and 1 are maskable |
| msg_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| intr_en | input | 1 | Core interrupt enable |
| tpr_we | input | 1 | Task priority write enable |
| tpr_wdata | input | 8 | Task priority write data |
| irq_ack | input | 1 | Core acknowledge of the request |
| irq_req | output | 1 | Interrupt request to the core |
| ack_valid | output | 1 | Acknowledge accepted this cycle |
| ack_vector | output | 8 | Vector delivered, valid with `ack_valid` |
| pend_vec | output | 8 | Highest pending vector |
| svc_vec | output | 8 | Vector currently in service |
| tpr | output | 8 | Task priority |
| irr | output | 256 | Request bits, one per vector |
| isr | output | 256 | In-service bits, one per vector |
| tmr | output | 256 | Trigger-mode bits, one per vector |
| err_unmaskable | output | 1 | Sticky flag for an unmaskable message |

## Verification
Some properties assume that a message and an acknowledge do not name the same vector in the same cycle. If they did, the new request would fold into the bit being cleared, and the in-service and request checks would not hold. The directed tests only send messages in cycles where `irq_ack` is low, so this case never arises. The other properties assume nothing about the inputs beyond a reset at the start of the run.

// File: rtl/irq_prioritizer.sv
module irq_prioritizer #(
  parameter int VEC_W  = 8,
  parameter int DEST_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [DEST_W-1:0]     local_id,
  input  logic                  msg_valid,
  input  logic [VEC_W-1:0]      msg_vector,
  input  logic [DEST_W-1:0]     msg_dest,
  input  logic                  msg_logical,
  input  logic [2:0]            msg_mode,
  input  logic                  msg_level,
  input  logic                  intr_en,
  input  logic                  tpr_we,
  input  logic [VEC_W-1:0]      tpr_wdata,
  input  logic                  irq_ack,
  output logic                  irq_req,
  output logic                  ack_valid,
  output logic [VEC_W-1:0]      ack_vector,
  output logic [VEC_W-1:0]      pend_vec,
  output logic [VEC_W-1:0]      svc_vec,
  output logic [VEC_W-1:0]      tpr,
  output logic [(1<<VEC_W)-1:0] irr,
  output logic [(1<<VEC_W)-1:0] isr,
  output logic [(1<<VEC_W)-1:0] tmr,
  output logic                  err_unmaskable
);
  localparam int NUM_VEC = 1 << VEC_W;
  localparam int PRI_LSB = VEC_W - 4;
  localparam int SEL_W   = $clog2(DEST_W);

  logic phys_hit, log_hit, hit, maskable, take, bad, new_set, ack_fire;
  logic [NUM_VEC-1:0] irr_n;
  logic [VEC_W-1:0]   top_idx, pend_n;

  assign phys_hit = !msg_logical && (msg_dest == local_id);
  assign log_hit  = msg_logical && (local_id[DEST_W-1:SEL_W] == '0)
                    && msg_dest[local_id[SEL_W-1:0]];
  assign hit      = msg_valid && (phys_hit || log_hit);
  assign maskable = (msg_mode[2:1] == 2'b00);
  assign take     = hit && maskable;
  assign bad      = hit && !maskable;
  assign new_set  = take && !irr[msg_vector];

  assign irq_req  = (pend_vec > svc_vec) && intr_en
                    && (pend_vec[VEC_W-1:PRI_LSB] > tpr[VEC_W-1:PRI_LSB]);
  assign ack_fire   = irq_ack && irq_req;
  assign ack_valid  = ack_fire;
  assign ack_vector = ack_fire ? pend_vec : '0;

  always_comb begin
    irr_n = irr;
    if (new_set)  irr_n[msg_vector] = 1'b1;
    if (ack_fire) irr_n[pend_vec]   = 1'b0;
  end

  always_comb begin
    top_idx = '0;
    for (int i = 0; i < NUM_VEC; i++)
      if (irr_n[i]) top_idx = VEC_W'(i);
  end

  always_comb begin
    if (ack_fire)                         pend_n = top_idx;
    else if (take && msg_vector > pend_vec) pend_n = msg_vector;
    else                                  pend_n = pend_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr            <= '0;
      isr            <= '0;
      tmr            <= '0;
      pend_vec       <= '0;
      svc_vec        <= '0;
      tpr            <= '0;
      err_unmaskable <= 1'b0;
    end else begin
      irr      <= irr_n;
      pend_vec <= pend_n;
      if (new_set) tmr[msg_vector] <= msg_level;
      if (ack_fire) begin
        svc_vec       <= pend_vec;
        isr[pend_vec] <= 1'b1;
      end
      if (bad)    err_unmaskable <= 1'b1;
      if (tpr_we) tpr <= tpr_wdata;
    end
  end
endmodule

// File: rtl/irq_prioritizer_chk.sv
module irq_prioritizer_chk #(
  parameter int VEC_W = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  msg_valid,
  input logic                  intr_en,
  input logic                  tpr_we,
  input logic [VEC_W-1:0]      tpr_wdata,
  input logic                  irq_req,
  input logic                  ack_valid,
  input logic [VEC_W-1:0]      ack_vector,
  input logic [VEC_W-1:0]      pend_vec,
  input logic [VEC_W-1:0]      svc_vec,
  input logic [VEC_W-1:0]      tpr,
  input logic [(1<<VEC_W)-1:0] irr,
  input logic [(1<<VEC_W)-1:0] isr,
  input logic [(1<<VEC_W)-1:0] tmr,
  input logic                  err_unmaskable
);
  AST_TMR_QUIET: assert property (@(posedge clk) disable iff (rst) !msg_valid |=> $stable(tmr)); // R3
  AST_PEND_NO_DROP: assert property (@(posedge clk) disable iff (rst) !ack_valid |=> pend_vec >= $past(pend_vec)); // R4
  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst) !intr_en |-> !irq_req); // R5
  AST_ACK_TO_SVC: assert property (@(posedge clk) disable iff (rst) ack_valid |=> svc_vec == $past(ack_vector)); // R6
  AST_ACK_MOVES_BIT: assert property (@(posedge clk) disable iff (rst) (ack_valid && !msg_valid) |=> (isr[$past(ack_vector)] && !irr[$past(ack_vector)])); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) err_unmaskable |=> err_unmaskable); // R8
  AST_TPR_WRITE: assert property (@(posedge clk) disable iff (rst) tpr_we |=> tpr == $past(tpr_wdata)); // R9
endmodule

bind irq_prioritizer irq_prioritizer_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/irq_prioritizer_bench.sv
module irq_prioritizer_bench;
  logic clk = 0, rst = 1;
  logic [7:0] local_id = 8'd3;
  logic msg_valid = 0, msg_logical = 0, msg_level = 0;
  logic [7:0] msg_vector = 0, msg_dest = 0;
  logic [2:0] msg_mode = 0;
  logic intr_en = 0, tpr_we = 0, irq_ack = 0;
  logic [7:0] tpr_wdata = 0;
  logic irq_req, ack_valid, err_unmaskable;
  logic [7:0] ack_vector, pend_vec, svc_vec, tpr;
  logic [255:0] irr, isr, tmr;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  irq_prioritizer u_irq_prioritizer (.*);

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1; msg_valid = 0; irq_ack = 0; tpr_we = 0; intr_en = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  task automatic send(input logic [7:0] v, input logic [7:0] d, input logic lg,
                      input logic [2:0] md, input logic lvl);
    msg_valid = 1; msg_vector = v; msg_dest = d; msg_logical = lg;
    msg_mode = md; msg_level = lvl;
    @(negedge clk);
    msg_valid = 0;
  endtask

  task automatic do_ack(output logic v, output logic [7:0] vec);
    irq_ack = 1;
    #1;
    v = ack_valid; vec = ack_vector;
    @(negedge clk);
    irq_ack = 0;
  endtask

  task automatic write_tpr(input logic [7:0] d);
    tpr_we = 1; tpr_wdata = d;
    @(negedge clk);
    tpr_we = 0;
  endtask

  function automatic logic [255:0] bit1(input int i);
    logic [255:0] b = '0;
    b[i] = 1'b1;
    return b;
  endfunction

  task automatic t_reset();
    do_reset();
    chk("R10 irq_req", irq_req, 0);
    chk("R10 ack_valid", ack_valid, 0);
    chk("R10 pend_vec", pend_vec, 0);
    chk("R10 svc_vec", svc_vec, 0);
    chk("R10 tpr", tpr, 0);
    chk("R10 irr", irr, 0);
    chk("R10 isr", isr, 0);
    chk("R10 tmr", tmr, 0);
    chk("R10 err", err_unmaskable, 0);
  endtask

  task automatic t_addressing();
    do_reset();
    send(8'h40, 8'd5, 0, 0, 0);
    chk("R11 physical miss irr", irr, 0);
    chk("R11 physical miss pend", pend_vec, 0);
    send(8'h40, 8'b0000_0100, 1, 0, 0);
    chk("R11 logical miss irr", irr, 0);
    send(8'h41, 8'b0000_1000, 1, 0, 1);
    chk("R1 logical hit irr", irr, bit1(8'h41));
    send(8'h42, 8'd3, 0, 1, 0);
    chk("R1 physical hit irr", irr, bit1(8'h41) | bit1(8'h42));
    chk("R2 mode 1 pend", pend_vec, 8'h42);
    send(8'h7f, 8'd5, 0, 4, 0);
    chk("R11 unaddressed unmaskable err", err_unmaskable, 0);
  endtask

  task automatic t_trigger();
    logic v; logic [7:0] vec;
    do_reset();
    intr_en = 1;
    send(8'h60, 8'd3, 0, 0, 1);
    chk("R3 level captured", tmr, bit1(8'h60));
    send(8'h60, 8'd3, 0, 0, 0);
    chk("R3 repeat leaves tmr", tmr, bit1(8'h60));
    chk("R2 repeat leaves irr", irr, bit1(8'h60));
    send(8'h61, 8'd3, 0, 0, 1);
    do_ack(v, vec);
    chk("R6 ack vector 61", vec, 8'h61);
    chk("R3 tmr kept after ack", tmr, bit1(8'h60) | bit1(8'h61));
    send(8'h61, 8'd3, 0, 0, 0);
    chk("R3 edge clears tmr", tmr, bit1(8'h60));
  endtask

  task automatic t_pending();
    logic v; logic [7:0] vec;
    do_reset();
    intr_en = 1;
    send(8'h30, 8'd3, 0, 0, 0);
    send(8'h90, 8'd3, 0, 0, 0);
    send(8'h50, 8'd3, 0, 0, 0);
    chk("R4 smaller keeps pend", pend_vec, 8'h90);
    chk("R5 req high", irq_req, 1);
    do_ack(v, vec);
    chk("R6 ack_valid", v, 1);
    chk("R6 ack_vector", vec, 8'h90);
    chk("R6 svc_vec", svc_vec, 8'h90);
    chk("R6 isr", isr, bit1(8'h90));
    chk("R6 irr cleared", irr, bit1(8'h30) | bit1(8'h50));
    chk("R7 recompute", pend_vec, 8'h50);
    chk("R5 below svc no req", irq_req, 0);
    do_ack(v, vec);
    chk("R6 ignored ack_valid", v, 0);
    chk("R6 ignored svc", svc_vec, 8'h90);
    chk("R6 ignored irr", irr, bit1(8'h30) | bit1(8'h50));
    send(8'h90, 8'd3, 0, 0, 0);
    chk("R4 raise pend", pend_vec, 8'h90);
    chk("R5 equal svc no req", irq_req, 0);
  endtask

  task automatic t_gate();
    do_reset();
    send(8'h45, 8'd3, 0, 0, 0);
    chk("R5 disabled no req", irq_req, 0);
    intr_en = 1; #1;
    chk("R5 enabled req", irq_req, 1);
    write_tpr(8'h40);
    chk("R9 tpr write", tpr, 8'h40);
    chk("R5 same class no req", irq_req, 0);
    write_tpr(8'h3f);
    chk("R5 lower class req", irq_req, 1);
    write_tpr(8'h50);
    chk("R5 higher class no req", irq_req, 0);
  endtask

  task automatic t_empty();
    logic v; logic [7:0] vec;
    do_reset();
    intr_en = 1;
    send(8'h20, 8'd3, 0, 0, 0);
    do_ack(v, vec);
    chk("R7 empty pend", pend_vec, 0);
    chk("R7 empty irr", irr, 0);
    chk("R7 no req", irq_req, 0);
  endtask

  task automatic t_unmask();
    do_reset();
    send(8'h70, 8'd3, 0, 4, 0);
    chk("R8 irr untouched", irr, 0);
    chk("R8 pend untouched", pend_vec, 0);
    chk("R8 err set", err_unmaskable, 1);
    send(8'h71, 8'd3, 0, 0, 0);
    chk("R8 err sticky", err_unmaskable, 1);
    send(8'h72, 8'd3, 0, 7, 0);
    chk("R8 mode 7 not queued", irr, bit1(8'h71));
  endtask

  initial begin
    #(8 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_addressing();
    t_trigger();
    t_pending();
    t_gate();
    t_empty();
    t_unmask();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule